// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller holds the chip's low-power mode and drives the supply enables of five power domains: the CPU (the main domain), the flash, the analog front end (comparator and ADC), the watchdog and the crystal oscillator. Software asks for one of four modes: run, idle, power-down or standby. The controller then moves the enables from their present pattern to the pattern of that mode. It changes one domain per step and waits a programmable number of cycles after each step.

Domains are switched off highest index first. Domains are switched on lowest index first, so the main domain always comes up before the peripherals. When a transition needs both kinds of step, every switch-off comes before any switch-on. In a sleeping mode, the wake events allowed by that mode return the chip to run. Only the domains that are off get switched on, so a shallower mode wakes in fewer steps. A request that arrives during a sequence is held until that sequence ends. The watchdog's counting is outside the block and arrives as an event input.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset all five enables are high, `busy` is low and `mode_o` is 0 (run).
- R2: Mode codes are 0 run, 1 idle, 2 power-down and 3 standby. Enable bits are 0 CPU, 1 flash, 2 analog front end, 3 watchdog and 4 oscillator. At the end of a sequence the enables equal the mode's pattern: run 11111, idle 11100, power-down 01000, standby 11000 (bit 4 on the left).
- R3: Each step changes exactly one enable. All switch-offs go from the highest index down, then all switch-ons go from the lowest index up.
- R4: Two consecutive steps are exactly G+1 cycles apart. G is the GAP_W-bit field at bit position i*GAP_W of `gap_cfg`, and i is the index of the domain switched by the earlier step. The sequence ends G+1 cycles after its last step, with G taken from the domain of that last step.
- R5: `gap_cfg` is captured when a sequence starts. Changing it while the sequence runs does not alter that sequence's timing.
- R6: A mode request that is sampled at a rising edge into an idle controller produces its first enable change two edges later. An accepted wake event produces its first enable change one edge later.
- R7: `busy` rises with the first enable change and falls when the last step's interval expires. A request that needs no change leaves `busy` low.
- R8: `mode_o` keeps its old value while a sequence runs and takes the new mode in the cycle that `busy` falls.
- R9: A request that arrives during a sequence is held. It starts one edge after that sequence ends.
- R10: Idle wakes on `ext_irq` or `int_irq`. Power-down and standby wake on `ext_irq` or `wdt_evt`. Any other event, and any event in run mode, leaves the enables, `busy` and `mode_o` unchanged.
- R11: A wake switches on only the domains that are off and ends in run mode. With equal gaps, a wake from standby completes in fewer cycles than a wake from power-down.
- R12: When a wake event and a held request are both present in an idle cycle, the wake is served first. The held request follows when the wake sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| gap_cfg | input | 5*GAP_W | Per-domain step interval in cycles, field i for domain i |
| ext_irq | input | 1 | External interrupt event |
| int_irq | input | 1 | Internal interrupt event |
| wdt_evt | input | 1 | Watchdog event |
| dom_en | output | 5 | Supply enable per domain |
| busy | output | 1 | A sequence is switching or waiting |
| mode_o | output | 2 | Mode currently in force |

## Verification
A wake event and a held mode request can both be present in the same idle cycle. The bench provokes this case by queuing a standby request behind a power-down sequence. It then raises `ext_irq` in the first cycle after that sequence ends. The enables must first replay the power-up to run and only afterwards step down to standby, and every cycle is compared against a timeline the bench computes from the gap fields. A request that lands in the middle of a sequence is checked the same way: the running sequence's step times must not move.

// File: rtl/pms_pkg.sv
package pms_pkg;
   localparam int PMS_NDOM = 5;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_PDOWN = 2'd2,
      PM_STBY  = 2'd3
   } pm_mode_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FIRST = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_t;

   localparam int DOM_CPU   = 0;
   localparam int DOM_FLASH = 1;
   localparam int DOM_AFE   = 2;
   localparam int DOM_WDT   = 3;
   localparam int DOM_XTAL  = 4;

   function automatic logic [PMS_NDOM-1:0] pm_mask(input pm_mode_t m);
      logic [PMS_NDOM-1:0] r;
      r = '0;
      case (m)
         PM_RUN:   r = '1;
         PM_IDLE:  begin r[DOM_AFE] = 1'b1; r[DOM_WDT] = 1'b1; r[DOM_XTAL] = 1'b1; end
         PM_PDOWN: r[DOM_WDT] = 1'b1;
         PM_STBY:  begin r[DOM_WDT] = 1'b1; r[DOM_XTAL] = 1'b1; end
         default:  r = '1;
      endcase
      return r;
   endfunction

   function automatic logic pm_wake(input pm_mode_t m, input logic ext_ev,
                                    input logic int_ev, input logic wdt_ev);
      logic r;
      case (m)
         PM_IDLE:           r = ext_ev | int_ev;
         PM_PDOWN, PM_STBY: r = ext_ev | wdt_ev;
         default:           r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pms_req_hold.sv
module pms_req_hold
   import pms_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_v,
   input  pm_mode_t in_mode,
   input  logic     take,
   output logic     out_v,
   output pm_mode_t out_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         out_mode <= PM_RUN;
      end else if (in_v) begin
         out_v    <= 1'b1;
         out_mode <= in_mode;
      end else if (take) begin
         out_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/pms_step_pick.sv
module pms_step_pick #(
   parameter int N  = 5,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  cur,
   input  logic [N-1:0]  tgt,
   output logic          vld,
   output logic [IW-1:0] idx,
   output logic          turn_on
);
   logic [N-1:0] off_v;
   logic [N-1:0] on_v;

   for (genvar d = 0; d < N; d++) begin : g_bit
      assign off_v[d] = cur[d] & ~tgt[d];
      assign on_v[d]  = ~cur[d] & tgt[d];
   end

   always_comb begin
      vld     = |(off_v | on_v);
      idx     = '0;
      turn_on = 1'b0;
      if (|off_v) begin
         for (int d = 0; d < N; d++)
            if (off_v[d]) idx = IW'(d);
      end else begin
         turn_on = 1'b1;
         for (int d = N - 1; d >= 0; d--)
            if (on_v[d]) idx = IW'(d);
      end
   end
endmodule

// File: rtl/pms_gap_timer.sv
module pms_gap_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int GAP_W = 4,
   localparam int ND = PMS_NDOM,
   localparam int IW = $clog2(ND)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic [ND*GAP_W-1:0] gap_cfg,
   input  logic              ext_irq,
   input  logic              int_irq,
   input  logic              wdt_evt,
   output logic [ND-1:0]     dom_en,
   output logic              busy,
   output logic [1:0]        mode_o
);
   if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
      $error("GAP_W must lie between 1 and 16");
   end

   sq_state_t         st;
   logic [ND-1:0]     en_q, tgt_q;
   logic [ND*GAP_W-1:0] gaps_q;
   pm_mode_t          cur_mode, tgt_mode;
   logic              busy_q;

   logic              pend_v;
   pm_mode_t          pend_mode;
   logic              wake_go, take;
   logic              pick_v, pick_on;
   logic [IW-1:0]     pick_idx;
   logic              tmr_zero, step_slot, step_fire;
   logic [GAP_W-1:0]  gap_sel;

   assign wake_go   = (st == SQ_IDLE) && pm_wake(cur_mode, ext_irq, int_irq, wdt_evt);
   assign take      = (st == SQ_IDLE) && !wake_go && pend_v;
   assign step_slot = (st == SQ_FIRST) || ((st == SQ_WAIT) && tmr_zero);
   assign step_fire = step_slot && pick_v;

   pms_req_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (req_valid),
      .in_mode  (pm_mode_t'(req_mode)),
      .take     (take),
      .out_v    (pend_v),
      .out_mode (pend_mode)
   );

   pms_step_pick #(.N(ND)) u_pick (
      .cur     (en_q),
      .tgt     (tgt_q),
      .vld     (pick_v),
      .idx     (pick_idx),
      .turn_on (pick_on)
   );

   always_comb begin
      gap_sel = '0;
      for (int d = 0; d < ND; d++)
         if (pick_idx == IW'(d)) gap_sel = gaps_q[d*GAP_W +: GAP_W];
   end

   pms_gap_timer #(.W(GAP_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (step_fire),
      .val   (gap_sel),
      .zero  (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         en_q     <= '1;
         tgt_q    <= '1;
         gaps_q   <= '0;
         cur_mode <= PM_RUN;
         tgt_mode <= PM_RUN;
         busy_q   <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (wake_go) begin
                  tgt_q    <= pm_mask(PM_RUN);
                  tgt_mode <= PM_RUN;
                  gaps_q   <= gap_cfg;
                  st       <= SQ_FIRST;
               end else if (pend_v) begin
                  tgt_q    <= pm_mask(pend_mode);
                  tgt_mode <= pend_mode;
                  gaps_q   <= gap_cfg;
                  st       <= SQ_FIRST;
               end
            end
            SQ_FIRST, SQ_WAIT: begin
               if (step_slot) begin
                  if (pick_v) begin
                     en_q[pick_idx] <= pick_on;
                     busy_q         <= 1'b1;
                     st             <= SQ_WAIT;
                  end else begin
                     busy_q   <= 1'b0;
                     cur_mode <= tgt_mode;
                     st       <= SQ_IDLE;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign dom_en = en_q;
   assign busy   = busy_q;
   assign mode_o = cur_mode;
endmodule

// File: rtl/pms_checker.sv
module pms_checker
   import pms_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [PMS_NDOM-1:0] dom_en,
   input logic                busy,
   input logic [1:0]          mode_o
);
   AST_ONE_DOMAIN_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dom_en ^ $past(dom_en)) <= 1); // R3

   AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_en != $past(dom_en)) |-> busy); // R7

   AST_MODE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(mode_o)); // R8

   AST_REST_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dom_en == pm_mask(pm_mode_t'(mode_o)))); // R2
endmodule

bind pwr_mode_seq pms_checker u_pms_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .dom_en (dom_en),
   .busy   (busy),
   .mode_o (mode_o)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
   localparam int GW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_mode = 2'd0;
   logic [5*GW-1:0] gap_cfg = '0;
   logic          ext_irq = 1'b0, int_irq = 1'b0, wdt_evt = 1'b0;
   logic [4:0]    dom_en;
   logic          busy;
   logic [1:0]    mode_o;

   int checks = 0;
   int errors = 0;
   logic [1:0] m = 2'd0;
   int e_pd, e_sb, e_x;

   always #10 clk = ~clk;

   pwr_mode_seq #(.GAP_W(GW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .gap_cfg(gap_cfg), .ext_irq(ext_irq), .int_irq(int_irq), .wdt_evt(wdt_evt),
      .dom_en(dom_en), .busy(busy), .mode_o(mode_o)
   );

   function automatic logic [4:0] bm(input logic [1:0] md);
      case (md)
         2'd0: return 5'b11111;
         2'd1: return 5'b11100;
         2'd2: return 5'b01000;
         default: return 5'b11000;
      endcase
   endfunction

   task automatic cmp(input string tag, input logic [4:0] ee, input logic eb,
                      input logic [1:0] emd, input int i);
      checks++;
      if (dom_en !== ee || busy !== eb || mode_o !== emd) begin
         errors++;
         $display("FAIL %s cycle %0d: en=%b busy=%b mode=%0d expected en=%b busy=%b mode=%0d",
                  tag, i, dom_en, busy, mode_o, ee, eb, emd);
      end
   endtask

   task automatic seq_check(input logic [4:0] fe, input logic [4:0] te,
                            input logic [1:0] fm, input logic [1:0] tm,
                            input int first, input int glitch_at,
                            input int req2_at, input logic [1:0] req2_mode,
                            input string tag, output int endi);
      int idx[10];
      int ct[10];
      int n;
      logic [5*GW-1:0] g;
      logic [4:0] e;
      n = 0;
      g = gap_cfg;
      for (int d = 4; d >= 0; d--) if (fe[d] && !te[d]) begin idx[n] = d; n++; end
      for (int d = 0; d < 5; d++)  if (!fe[d] && te[d]) begin idx[n] = d; n++; end
      if (n > 0) begin
         ct[0] = first;
         for (int k = 1; k < n; k++)
            ct[k] = ct[k-1] + int'(g[idx[k-1]*GW +: GW]) + 1;
         endi = ct[n-1] + int'(g[idx[n-1]*GW +: GW]) + 1;
      end else begin
         endi = first;
      end
      for (int i = 1; i <= endi; i++) begin
         @(negedge clk);
         e = fe;
         for (int k = 0; k < n; k++) if (ct[k] <= i) e[idx[k]] = te[idx[k]];
         cmp(tag, e, (n > 0) && (i >= first) && (i < endi), (i >= endi) ? tm : fm, i);
         if (i == 1) begin
            req_valid = 1'b0; ext_irq = 1'b0; int_irq = 1'b0; wdt_evt = 1'b0;
         end
         if (i == glitch_at) gap_cfg = ~gap_cfg;
         if (i == req2_at) begin req_valid = 1'b1; req_mode = req2_mode; end
         if (req2_at > 0 && i == req2_at + 1) req_valid = 1'b0;
      end
   endtask

   task automatic watch(input int n, input logic [4:0] ee, input logic [1:0] emd,
                        input string tag);
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         cmp(tag, ee, 1'b0, emd, i);
         if (i == 1) begin ext_irq = 1'b0; int_irq = 1'b0; wdt_evt = 1'b0; end
      end
   endtask

   task automatic goto_mode(input logic [1:0] x);
      int en_i;
      req_valid = 1'b1;
      req_mode  = x;
      seq_check(bm(m), bm(x), m, x, 3, 0, 0, 2'd0, "R2 R3 R4 R6 R7 R8", en_i);
      m = x;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 reset state", 5'b11111, 1'b0, 2'd0, 0);

      // near-exhaustive transition sweep under two gap patterns
      for (int p = 0; p < 2; p++) begin
         gap_cfg = (p == 0) ? 20'h01234 : 20'h30A21;
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               goto_mode(2'(a));
               goto_mode(2'(b));
            end
      end
      goto_mode(2'd0);

      // R5: interval fields changed mid-sequence have no effect
      gap_cfg = 20'h21312;
      req_valid = 1'b1; req_mode = 2'd2;
      seq_check(bm(0), bm(2), 2'd0, 2'd2, 3, 3, 0, 2'd0, "R5 latched intervals", e_x);
      m = 2'd2;
      gap_cfg = 20'h22222;

      // R10: disallowed wake in power-down
      int_irq = 1'b1;
      watch(6, bm(2), 2'd2, "R10 int_irq ignored in power-down");

      // R11: wake latency power-down vs standby
      ext_irq = 1'b1;
      seq_check(bm(2), bm(0), 2'd2, 2'd0, 2, 0, 0, 2'd0, "R10 R11 power-down wake", e_pd);
      m = 2'd0;
      goto_mode(2'd3);
      int_irq = 1'b1;
      watch(6, bm(3), 2'd3, "R10 int_irq ignored in standby");
      wdt_evt = 1'b1;
      seq_check(bm(3), bm(0), 2'd3, 2'd0, 2, 0, 0, 2'd0, "R10 R11 standby wake", e_sb);
      m = 2'd0;
      checks++;
      if (!(e_sb < e_pd)) begin
         errors++;
         $display("FAIL R11 standby wake %0d cycles, expected fewer than power-down %0d", e_sb, e_pd);
      end

      // R10: idle wakes on internal interrupt; run ignores events
      goto_mode(2'd1);
      wdt_evt = 1'b1;
      watch(6, bm(1), 2'd1, "R10 wdt_evt ignored in idle");
      int_irq = 1'b1;
      seq_check(bm(1), bm(0), 2'd1, 2'd0, 2, 0, 0, 2'd0, "R10 idle wake", e_x);
      m = 2'd0;
      ext_irq = 1'b1; wdt_evt = 1'b1; int_irq = 1'b1;
      watch(6, bm(0), 2'd0, "R10 events ignored in run");

      // R9: request during a sequence held until it ends
      req_valid = 1'b1; req_mode = 2'd2;
      seq_check(bm(0), bm(2), 2'd0, 2'd2, 3, 0, 4, 2'd1, "R9 first sequence", e_x);
      seq_check(bm(2), bm(1), 2'd2, 2'd1, 2, 0, 0, 2'd0, "R9 held request", e_x);
      m = 2'd1;

      // R12: wake and held request in the same idle cycle
      req_valid = 1'b1; req_mode = 2'd2;
      seq_check(bm(1), bm(2), 2'd1, 2'd2, 3, 0, 4, 2'd3, "R12 lead-in", e_x);
      ext_irq = 1'b1;
      seq_check(bm(2), bm(0), 2'd2, 2'd0, 2, 0, 0, 2'd0, "R12 wake first", e_x);
      seq_check(bm(0), bm(3), 2'd0, 2'd3, 2, 0, 0, 2'd0, "R12 held request after wake", e_x);
      m = 2'd3;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule